// File: doc/BRIEF.md
# Fractional M/N Clock-Enable Generator

This block turns a double-rate tick into a stream of one-cycle enable pulses at a lower, possibly fractional, average rate. The tick arrives twice per source clock period. A pre-divider counts these ticks, so it can divide the source by whole or half-integer ratios. Its pulses then feed an M/N accumulator, which keeps only m out of every n of them on average. The block also drives a divided-clock level that rises with each enable and is high for roughly half of each output period.

The divider, mode and M/N/D fields are presented in their stored encodings. The N field holds the inverse of (n−m) and the D field holds the inverse of n. A new setting is taken up only on a tick that produces an enable, so a period in progress is never cut short. Selecting the clock source and switching sources without glitches are left to surrounding logic.

Top module: `mnd_clk_gen`

## Requirements
- R1: After reset, `clk_en` and `clk_lvl` are low. The active setting is divider 0 with the M/N stage off.
- R2: With divider field 0 and the M/N stage bypassed, one enable is produced for every 2 ticks.
- R3: With a divider field h other than 0 and the M/N stage bypassed, one enable is produced for every h+1 ticks. The output rate is therefore 2·source/(h+1).
- R4: `clk_en` is high for exactly one clock, in the cycle after the clock on which a firing tick is sampled. It is never high without a tick in the previous cycle.
- R5: With `cfg_mnd_on` set, n is decoded as (~`cfg_n_inv` & (2^MND_W−1)) + m. On each pre-divided pulse, m is added to a remainder. When the sum reaches or exceeds n, the pulse fires and n is subtracted; otherwise the sum is kept.
- R6: With m equal to n (N field all ones), every pre-divided pulse fires.
- R7: With `cfg_mnd_on` clear, or with m equal to 0, the M/N stage is bypassed and every pre-divided pulse fires.
- R8: The setting inputs are captured only on a tick that fires. Changes made between firing ticks have no effect on outputs until then.
- R9: When the captured setting differs from the active one, the remainder restarts at 0. When it is unchanged, the remainder carries over.
- R10: `clk_lvl` rises with every enable. While high, it falls on the tick at pre-divider count (P−1)/2, rounded down, when the next pre-divided pulse will fire. P is the pre-divider period in ticks.
- R11: With the M/N stage active, a high `clk_lvl` also falls on a non-firing pre-divided pulse whose new remainder is at least floor(dn/2). Here dn = ~`cfg_d_inv` & (2^MND_W−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_2x | input | 1 | Double-rate tick, one-cycle enable |
| cfg_div | input | DIV_W | Half-integer pre-divider field (0 = divide by 1) |
| cfg_mnd_on | input | 1 | Enables the M/N stage |
| cfg_m | input | MND_W | Numerator m |
| cfg_n_inv | input | MND_W | Inverse of (n−m) |
| cfg_d_inv | input | MND_W | Inverse of n, used for duty shaping |
| clk_lvl | output | 1 | Divided-clock level |
| clk_en | output | 1 | One-cycle enable at each rising output edge |

## Verification
Widely spaced ticks are used with divider values 0, odd and even, and with the M/N stage off. This separates the two period rules. A 3/8 fraction then exercises remainder carry and the duty rule driven by the D field. A 5/5 setting and an m of zero show the pass-all and bypass paths. Settings are changed in mid-period, toggled and restored between pulses, and reloaded unchanged, which exposes loading at the wrong time and remainder handling. Back-to-back ticks stress the single-cycle enable.

// File: rtl/mnd_pkg.sv
package mnd_pkg;
  localparam int DIV_W = 5;
  localparam int MND_W = 8;
  localparam int ACC_W = MND_W + 2;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             mnd_on;
    logic [MND_W-1:0] m;
    logic [MND_W-1:0] n_inv;
    logic [MND_W-1:0] d_inv;
  } gen_cfg_t;
endpackage

// File: rtl/mnd_prediv.sv
module mnd_prediv #(
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] div,
  output logic          pre_pulse,
  output logic          mid_tick
);
  localparam int CW = DW + 1;

  logic [CW-1:0] period;
  logic [CW-1:0] last_cnt;
  logic [CW-1:0] mid_cnt;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (div == '0) period = CW'(2);
    else           period = {1'b0, div} + CW'(1);
    last_cnt  = period - CW'(1);
    mid_cnt   = last_cnt >> 1;
    pre_pulse = tick && (cnt_q == last_cnt);
    mid_tick  = tick && !pre_pulse && (cnt_q == mid_cnt);
    cnt_d     = cnt_q;
    if (tick) begin
      if (pre_pulse) cnt_d = '0;
      else           cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < period);
endmodule

// File: rtl/mnd_accum.sv
module mnd_accum #(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_pulse,
  input  logic          mnd_on,
  input  logic [MW-1:0] m,
  input  logic [MW-1:0] n_inv,
  input  logic          clear,
  output logic          bypass,
  output logic          will_fire,
  output logic [MW+1:0] acc_nxt
);
  localparam int AW = MW + 2;

  logic [MW-1:0] n_diff;
  logic [AW-1:0] n_dec;
  logic [AW-1:0] sum;
  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_d;
  logic          reached;

  always_comb begin
    n_diff    = ~n_inv;
    n_dec     = AW'(n_diff) + AW'(m);
    sum       = acc_q + AW'(m);
    reached   = (sum >= n_dec);
    bypass    = !mnd_on || (m == '0);
    will_fire = bypass || reached;
    acc_nxt   = acc_q;
    if (pre_pulse) begin
      if (bypass)       acc_nxt = '0;
      else if (reached) acc_nxt = sum - n_dec;
      else              acc_nxt = sum;
    end
    acc_d = clear ? '0 : acc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R5
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass |-> (acc_q < n_dec));
endmodule

// File: rtl/mnd_level.sv
module mnd_level #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          mid_tick,
  input  logic          pre_pulse,
  input  logic          bypass,
  input  logic          will_fire,
  input  logic [AW-1:0] acc_nxt,
  input  logic [AW-1:0] d_half,
  output logic          lvl
);
  logic lvl_q;
  logic lvl_d;
  logic fall;

  always_comb begin
    fall = lvl_q && !fire &&
           ((mid_tick && will_fire) ||
            (pre_pulse && !bypass && (acc_nxt >= d_half)));
    lvl_d = lvl_q;
    if (fire)      lvl_d = 1'b1;
    else if (fall) lvl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign lvl = lvl_q;

  // R10
  lvl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> lvl_q);
endmodule

// File: rtl/mnd_clk_gen.sv
module mnd_clk_gen
  import mnd_pkg::*;
#(
  parameter int GDIV_W = DIV_W,
  parameter int GMND_W = MND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_2x,
  input  logic [GDIV_W-1:0] cfg_div,
  input  logic              cfg_mnd_on,
  input  logic [GMND_W-1:0] cfg_m,
  input  logic [GMND_W-1:0] cfg_n_inv,
  input  logic [GMND_W-1:0] cfg_d_inv,
  output logic              clk_lvl,
  output logic              clk_en
);
  localparam int GACC_W = GMND_W + 2;

  logic rst_meta;
  logic rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  gen_cfg_t cfg_in;
  gen_cfg_t act_q;
  gen_cfg_t act_d;
  logic     changed;
  logic     fire;
  logic     pre_pulse;
  logic     mid_tick;
  logic     bypass;
  logic     will_fire;
  logic [GACC_W-1:0] acc_nxt;
  logic [GMND_W-1:0] d_val;
  logic [GACC_W-1:0] d_half;
  logic     en_q;

  always_comb begin
    cfg_in.div    = cfg_div;
    cfg_in.mnd_on = cfg_mnd_on;
    cfg_in.m      = cfg_m;
    cfg_in.n_inv  = cfg_n_inv;
    cfg_in.d_inv  = cfg_d_inv;
    changed       = (cfg_in != act_q);
    fire          = pre_pulse && will_fire;
    act_d         = fire ? cfg_in : act_q;
    d_val         = ~act_q.d_inv;
    d_half        = GACC_W'(d_val) >> 1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      act_q <= '0;
      en_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      en_q  <= fire;
    end
  end

  mnd_prediv #(.DW(GDIV_W)) u_prediv (
    .clk       (clk),
    .rst_n     (rst_q),
    .tick      (tick_2x),
    .div       (act_q.div),
    .pre_pulse (pre_pulse),
    .mid_tick  (mid_tick)
  );

  mnd_accum #(.MW(GMND_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_q),
    .pre_pulse (pre_pulse),
    .mnd_on    (act_q.mnd_on),
    .m         (act_q.m),
    .n_inv     (act_q.n_inv),
    .clear     (fire && changed),
    .bypass    (bypass),
    .will_fire (will_fire),
    .acc_nxt   (acc_nxt)
  );

  mnd_level #(.AW(GACC_W)) u_level (
    .clk       (clk),
    .rst_n     (rst_q),
    .fire      (fire),
    .mid_tick  (mid_tick),
    .pre_pulse (pre_pulse),
    .bypass    (bypass),
    .will_fire (will_fire),
    .acc_nxt   (acc_nxt),
    .d_half    (d_half),
    .lvl       (clk_lvl)
  );

  assign clk_en = en_q;

  // R4
  en_single_chk: assert property (@(posedge clk) disable iff (!rst_q)
    clk_en |=> !clk_en);
  // R4
  en_tick_chk: assert property (@(posedge clk) disable iff (!rst_q)
    clk_en |-> $past(tick_2x));
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !fire |=> $stable(act_q));
  // R10
  lvl_en_chk: assert property (@(posedge clk) disable iff (!rst_q)
    clk_en |-> clk_lvl);
endmodule

// File: tb/mnd_clk_gen_test.sv
module mnd_clk_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_2x;
  logic [4:0] cfg_div;
  logic       cfg_mnd_on;
  logic [7:0] cfg_m, cfg_n_inv, cfg_d_inv;
  logic       clk_lvl, clk_en;

  always #10 clk = ~clk;

  mnd_clk_gen uut (
    .clk(clk), .rst_n(rst_n), .tick_2x(tick_2x), .cfg_div(cfg_div),
    .cfg_mnd_on(cfg_mnd_on), .cfg_m(cfg_m), .cfg_n_inv(cfg_n_inv),
    .cfg_d_inv(cfg_d_inv), .clk_lvl(clk_lvl), .clk_en(clk_en));

  int total = 0;
  int bad = 0;
  int tick_idx = 0;
  int exp_q[$];
  string tag = "R1";
  bit done = 0;

  int a_div, a_mode, a_m, a_nr, a_dr;
  int pcnt, acc;
  bit lvl;

  function automatic int enc_n(int m, int n);
    return (~(n - m)) & 255;
  endfunction
  function automatic int enc_d(int n);
    return (~n) & 255;
  endfunction

  task automatic set_cfg(int dv, int md, int m, int n);
    cfg_div = 5'(dv); cfg_mnd_on = md[0];
    cfg_m = 8'(m); cfg_n_inv = 8'(enc_n(m, n)); cfg_d_inv = 8'(enc_d(n));
  endtask

  task automatic model_tick();
    int p, n, dh, sum, accn;
    bit byp, pre, will, fire, mid, fall, chg;
    p = (a_div == 0) ? 2 : a_div + 1;
    byp = (a_mode == 0) || (a_m == 0);
    n = ((~a_nr) & 255) + a_m;
    dh = ((~a_dr) & 255) >> 1;
    pre = (pcnt == p - 1);
    sum = acc + a_m;
    will = byp || (sum >= n);
    fire = pre && will;
    accn = pre ? (byp ? 0 : (sum >= n ? sum - n : sum)) : acc;
    mid = !pre && (pcnt == ((p - 1) >> 1));
    fall = lvl && !fire && ((mid && will) || (pre && !byp && accn >= dh));
    pcnt = pre ? 0 : pcnt + 1;
    tick_idx++;
    if (fire) begin
      exp_q.push_back(tick_idx);
      chg = (a_div != cfg_div) || (a_mode != cfg_mnd_on) || (a_m != cfg_m) ||
            (a_nr != cfg_n_inv) || (a_dr != cfg_d_inv);
      a_div = cfg_div; a_mode = cfg_mnd_on; a_m = cfg_m;
      a_nr = cfg_n_inv; a_dr = cfg_d_inv;
      acc = chg ? 0 : accn;
      lvl = 1;
    end else begin
      acc = accn;
      if (fall) lvl = 0;
    end
  endtask

  // one clock: called at a negedge, returns at the next negedge
  task automatic step(bit t);
    tick_2x = t;
    @(posedge clk);
    if (t) model_tick();
    @(negedge clk);
    tick_2x = 1'b0;
    total++;
    if (clk_lvl !== lvl) begin
      bad++;
      $display("FAIL %s R10 R11 level at tick %0d: actual=%0b expected=%0b",
               tag, tick_idx, clk_lvl, lvl);
    end
  endtask

  task automatic run(int n, int gap);
    for (int i = 0; i < n; i++) begin
      step(1'b1);
      for (int g = 0; g < gap; g++) step(1'b0);
    end
  endtask

  // monitor: pops expected enable ticks
  always @(negedge clk) begin
    if (rst_n && clk_en === 1'b1) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL %s R4 unexpected enable: actual=tick %0d expected=none",
                 tag, tick_idx);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != tick_idx) begin
          bad++;
          $display("FAIL %s enable tick: actual=%0d expected=%0d", tag, tick_idx, e);
        end
      end
    end
  end

  initial begin
    #3_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    a_div = 0; a_mode = 0; a_m = 0; a_nr = 0; a_dr = 0;
    pcnt = 0; acc = 0; lvl = 0;
    rst_n = 1'b0; tick_2x = 1'b0;
    cfg_div = '0; cfg_mnd_on = 1'b0; cfg_m = '0; cfg_n_inv = '0; cfg_d_inv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    total++;
    if (clk_en !== 1'b0 || clk_lvl !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset outputs: actual=%0b%0b expected=00", clk_en, clk_lvl);
    end
    tag = "R2"; run(12, 2);
    tag = "R3"; set_cfg(4, 0, 0, 0); run(25, 2);
    tag = "R3"; set_cfg(3, 0, 0, 0); run(20, 1);
    tag = "R5"; set_cfg(0, 1, 3, 8); run(40, 1);
    tag = "R9"; run(24, 1);
    tag = "R11"; set_cfg(2, 1, 3, 8); run(30, 1);
    tag = "R6"; set_cfg(0, 1, 5, 5); run(16, 1);
    tag = "R7"; set_cfg(1, 1, 0, 9); run(12, 1);
    tag = "R7"; set_cfg(0, 0, 3, 8); run(12, 1);
    // R8: long period, change in mid-period, then toggle and restore
    tag = "R8"; set_cfg(9, 0, 0, 0); run(12, 1);
    run(3, 1); set_cfg(2, 0, 0, 0); run(5, 1);
    set_cfg(7, 1, 1, 4); step(1'b1); set_cfg(2, 0, 0, 0); run(12, 1);
    tag = "R9"; set_cfg(0, 1, 3, 7); run(30, 1);
    tag = "R4"; set_cfg(0, 0, 0, 0); run(20, 0);
    tag = "R4"; set_cfg(0, 1, 2, 3); run(20, 0);
    repeat (4) step(1'b0);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R4 pending enables: actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule